// File: doc/BRIEF.md
# Multi-Mode 8-Bit Waveform Timer

This block is an up/down counter with one compare register and one waveform output. A 2-bit mode field selects how it counts. Normal mode runs freely through the full range. Phase-correct PWM counts up to the full-scale value and then back down. Clear-on-compare mode wraps at the compare value. Fast PWM counts up and wraps at full scale. A 2-bit output-action field sets how the waveform bit reacts to compare matches and to the wrap point. The counter moves only when the `tick` enable input is high, so the block relies on an external prescaler for its time base.

Software can write the counter, the compare value and the control fields through single-cycle write strobes. In the two PWM modes a compare write goes into a holding register and reaches the comparator only when the counter passes full scale. This keeps every PWM period glitch-free. Two sticky flags report overflow and compare events, and each is cleared by a write-one pulse. The waveform takes over the pin whenever the output-action field is nonzero. The pin driver is enabled only when the direction input is also set.

Top module: `wave_timer`

## Requirements
- R1: `count` changes only on a cycle with `tick` high or with `cntWrEn` high. A counter write takes priority over a tick in the same cycle, and `count` shows the written value one cycle later.
- R2: In normal mode (`ctlMode`=0) the counter goes up by one per tick and wraps from 255 to 0. `ovfFlag` sets on the tick that leaves 255.
- R3: In clear-on-compare mode (`ctlMode`=2) the counter goes from the active compare value to 0. `ovfFlag` sets only on a tick that leaves 255, for example after the counter was written above the compare value.
- R4: In modes 0 and 2, a tick taken while `count` equals the active compare value is a match. On a match, output action 1 toggles `waveOut`, 2 clears it and 3 sets it. Action 0 leaves it unchanged.
- R5: In modes 0 and 2 a compare write reaches the comparator at once. In modes 1 and 3 it is held, and it reaches the comparator on the tick that leaves count 255.
- R6: In fast PWM (`ctlMode`=3) with compare value C, action 2 sets `waveOut` on the tick that leaves 255 and clears it on a match, so it is high for C+1 of every 256 ticks. Action 3 gives the inverse (255-C high). Action 1 leaves `waveOut` unchanged.
- R7: In fast PWM with C=255 and action 2 or 3, the wrap action wins over the match. The output stays high for all 256 ticks with action 2 and low for all 256 ticks with action 3.
- R8: In phase-correct mode (`ctlMode`=1) the counter rises to 255, turns and falls to 0, then rises again, for a period of 510 ticks. `ovfFlag` sets on the tick that leaves 0 while falling, and not at 255.
- R9: In phase-correct mode, action 2 clears `waveOut` on a rising match and sets it on a falling match, which gives 2C high ticks per 510. Action 3 is the inverse (510-2C high).
- R10: `pinOvr` is high whenever the output-action field is nonzero. `pinDrvEn` is high only when `pinOvr` and `pinDir` are both high.
- R11: The first tick after a counter write never produces a match. Neither `waveOut` nor `cmpFlag` changes on that tick, even when the written value equals the compare value.
- R12: `ovfFlag` and `cmpFlag` stay set until a one on `ovfClr` or `cmpClr` clears them. A set event in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from the prescaler |
| cntWrEn | input | 1 | Counter write strobe |
| cntWrData | input | 8 | Counter write value |
| cmpWrEn | input | 1 | Compare write strobe |
| cmpWrData | input | 8 | Compare write value |
| ctlWrEn | input | 1 | Control write strobe |
| ctlMode | input | 2 | Counting mode: 0 normal, 1 phase-correct, 2 clear-on-compare, 3 fast PWM |
| ctlOut | input | 2 | Output action select |
| pinDir | input | 1 | Pin direction (1 = output) |
| ovfClr | input | 1 | Write-one clear of ovfFlag |
| cmpClr | input | 1 | Write-one clear of cmpFlag |
| count | output | 8 | Current counter value |
| waveOut | output | 1 | Waveform bit |
| pinOvr | output | 1 | Waveform overrides the pin function |
| pinDrvEn | output | 1 | Pin output driver enable |
| ovfFlag | output | 1 | Sticky overflow flag |
| cmpFlag | output | 1 | Sticky compare flag |

## Verification
Every result is one register stage from the edge that takes its cause. A tick, write or clear driven before a rising edge shows on `count`, `waveOut` and the flags right after that edge. The bench therefore drives inputs on the falling edge and samples on the next falling edge. A scenario of n ticks is judged exactly n edges after its first tick. Duty cycles are counted over exactly one period (256 or 510 ticks), and only after at least one full period has passed, so that held compare values have reached the comparator first.

// File: rtl/wave_timer_pkg.sv
package wave_timer_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_PHASE  = 2'd1,
    MODE_CTC    = 2'd2,
    MODE_FAST   = 2'd3
  } modeT;

  typedef enum logic [1:0] {
    ACT_OFF = 2'd0,
    ACT_TGL = 2'd1,
    ACT_CLR = 2'd2,
    ACT_SET = 2'd3
  } actT;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic step;      // counter advances this cycle
    logic clrCount;  // wrap to zero
    logic decCount;  // count down instead of up
    logic setDown;   // start falling slope
    logic setUp;     // start rising slope
    logic loadCmp;   // copy held compare into active compare
    logic setOvf;
    logic setCmp;
    logic waveSet;
    logic waveClr;
    logic waveTgl;
  } strobeT;
endpackage

// File: rtl/wave_timer_ctrl.sv
module wave_timer_ctrl
  import wave_timer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             tick,
  input  logic             cntWrEn,
  input  logic [WIDTH-1:0] cnt,
  input  logic [WIDTH-1:0] cmpActive,
  input  logic             dirDown,
  input  logic             blockMatch,
  input  modeT             mode,
  input  actT              act,
  output strobeT           strb
);
  localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

  logic             step;
  logic             atMax;
  logic             atZero;
  logic             hit;
  logic [WIDTH-1:0] topVal;

  always_comb begin
    step   = tick && !cntWrEn;
    atMax  = (cnt == MAXV);
    atZero = (cnt == '0);
    hit    = step && !blockMatch && (cnt == cmpActive);
    topVal = (mode == MODE_CTC) ? cmpActive : MAXV;

    strb        = '0;
    strb.step   = step;
    strb.setCmp = hit;

    if (mode == MODE_PHASE) begin
      if (!dirDown && atMax) begin
        strb.decCount = 1'b1;
        strb.setDown  = step;
      end else if (dirDown && atZero) begin
        strb.setUp = step;
      end else begin
        strb.decCount = dirDown;
      end
      strb.setOvf  = step && dirDown && atZero;
      strb.loadCmp = step && atMax;
      if (hit && act[1]) begin
        // rising: action 2 clears; falling: action 2 sets
        if (act[0] == dirDown) strb.waveClr = 1'b1;
        else                   strb.waveSet = 1'b1;
      end
    end else begin
      strb.clrCount = (cnt == topVal);
      strb.setOvf   = step && atMax;
      strb.loadCmp  = (mode == MODE_FAST) && step && atMax;
      if (mode == MODE_FAST) begin
        if (step && atMax && act[1]) begin
          // wrap action has priority; hides a match at full scale
          strb.waveSet = (act == ACT_CLR);
          strb.waveClr = (act == ACT_SET);
        end else if (hit && act[1]) begin
          strb.waveClr = (act == ACT_CLR);
          strb.waveSet = (act == ACT_SET);
        end
      end else if (hit) begin
        strb.waveTgl = (act == ACT_TGL);
        strb.waveClr = (act == ACT_CLR);
        strb.waveSet = (act == ACT_SET);
      end
    end
  end
endmodule

// File: rtl/wave_timer_dp.sv
module wave_timer_dp
  import wave_timer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cntWrEn,
  input  logic [WIDTH-1:0] cntWrData,
  input  logic             cmpWrEn,
  input  logic [WIDTH-1:0] cmpWrData,
  input  logic             ctlWrEn,
  input  logic [1:0]       ctlMode,
  input  logic [1:0]       ctlOut,
  input  logic             ovfClr,
  input  logic             cmpClr,
  input  strobeT           strb,
  output logic [WIDTH-1:0] cnt,
  output logic [WIDTH-1:0] cmpActive,
  output logic             dirDown,
  output logic             blockMatch,
  output modeT             mode,
  output actT              act,
  output logic             wave,
  output logic             ovfFlag,
  output logic             cmpFlag
);
  logic [WIDTH-1:0] cmpHeld;
  logic             pwmMode;

  assign pwmMode = (mode == MODE_PHASE) || (mode == MODE_FAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      cmpHeld    <= '0;
      cmpActive  <= '0;
      dirDown    <= 1'b0;
      blockMatch <= 1'b0;
      mode       <= MODE_NORMAL;
      act        <= ACT_OFF;
      wave       <= 1'b0;
      ovfFlag    <= 1'b0;
      cmpFlag    <= 1'b0;
    end else begin
      if (ctlWrEn) begin
        mode <= modeT'(ctlMode);
        act  <= actT'(ctlOut);
      end

      if (cntWrEn)            cnt <= cntWrData;
      else if (strb.step) begin
        if (strb.clrCount)      cnt <= '0;
        else if (strb.decCount) cnt <= cnt - 1'b1;
        else                    cnt <= cnt + 1'b1;
      end

      if (mode != MODE_PHASE) dirDown <= 1'b0;
      else if (strb.setDown)  dirDown <= 1'b1;
      else if (strb.setUp)    dirDown <= 1'b0;

      if (cntWrEn)   blockMatch <= 1'b1;
      else if (tick) blockMatch <= 1'b0;

      if (cmpWrEn) cmpHeld <= cmpWrData;
      if (cmpWrEn && !pwmMode)            cmpActive <= cmpWrData;
      else if (strb.loadCmp && pwmMode)   cmpActive <= cmpHeld;

      if (strb.waveTgl)      wave <= ~wave;
      else if (strb.waveSet) wave <= 1'b1;
      else if (strb.waveClr) wave <= 1'b0;

      if (strb.setOvf) ovfFlag <= 1'b1;
      else if (ovfClr) ovfFlag <= 1'b0;

      if (strb.setCmp) cmpFlag <= 1'b1;
      else if (cmpClr) cmpFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wave_timer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cntWrEn,
  input  logic [WIDTH-1:0] cntWrData,
  input  logic             cmpWrEn,
  input  logic [WIDTH-1:0] cmpWrData,
  input  logic             ctlWrEn,
  input  logic [1:0]       ctlMode,
  input  logic [1:0]       ctlOut,
  input  logic             pinDir,
  input  logic             ovfClr,
  input  logic             cmpClr,
  output logic [WIDTH-1:0] count,
  output logic             waveOut,
  output logic             pinOvr,
  output logic             pinDrvEn,
  output logic             ovfFlag,
  output logic             cmpFlag
);
  strobeT           strb;
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] cmpActive;
  logic             dirDown;
  logic             blockMatch;
  modeT             modeQ;
  actT              actQ;

  wave_timer_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .tick       (tick),
    .cntWrEn    (cntWrEn),
    .cnt        (cnt),
    .cmpActive  (cmpActive),
    .dirDown    (dirDown),
    .blockMatch (blockMatch),
    .mode       (modeQ),
    .act        (actQ),
    .strb       (strb)
  );

  wave_timer_dp #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cntWrEn    (cntWrEn),
    .cntWrData  (cntWrData),
    .cmpWrEn    (cmpWrEn),
    .cmpWrData  (cmpWrData),
    .ctlWrEn    (ctlWrEn),
    .ctlMode    (ctlMode),
    .ctlOut     (ctlOut),
    .ovfClr     (ovfClr),
    .cmpClr     (cmpClr),
    .strb       (strb),
    .cnt        (cnt),
    .cmpActive  (cmpActive),
    .dirDown    (dirDown),
    .blockMatch (blockMatch),
    .mode       (modeQ),
    .act        (actQ),
    .wave       (waveOut),
    .ovfFlag    (ovfFlag),
    .cmpFlag    (cmpFlag)
  );

  assign count    = cnt;
  assign pinOvr   = (actQ != ACT_OFF);
  assign pinDrvEn = pinOvr & pinDir;
endmodule

// File: rtl/wave_timer_chk.sv
module wave_timer_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cntWrEn,
  input logic             ctlWrEn,
  input logic [WIDTH-1:0] count,
  input logic             waveOut,
  input logic             ovfFlag,
  input logic             cmpFlag,
  input logic [1:0]       modeQ,
  input logic [1:0]       actQ
);
  localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic fast2;
  assign fast2 = (modeQ == 2'd3) && (actQ == 2'd2);

  // R1: counter holds without a tick or a write
  a_r1_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cntWrEn |=> $stable(count));

  // R4: waveform moves only on a tick
  a_r4_wave_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(waveOut));

  // R12: overflow flag rises only from a tick
  a_r12_ovf_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovfFlag) |-> $past(tick));

  // R11: first tick after a counter write gives no compare event
  a_r11_block_match: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cntWrEn) && tick && !cmpFlag |=> !cmpFlag);

  // R6: non-inverting fast PWM rises only when leaving full scale
  a_r6_fast_rise_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(waveOut) && $past(fast2) |-> $past(count) == MAXV);

  // R8: phase-correct count moves by exactly one per tick
  a_r8_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == 2'd1) && tick && !cntWrEn && !ctlWrEn |=>
      (WIDTH'(count - $past(count)) == ONE) || (WIDTH'($past(count) - count) == ONE));
endmodule

bind wave_timer wave_timer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .cntWrEn (cntWrEn),
  .ctlWrEn (ctlWrEn),
  .count   (count),
  .waveOut (waveOut),
  .ovfFlag (ovfFlag),
  .cmpFlag (cmpFlag),
  .modeQ   (modeQ),
  .actQ    (actQ)
);

// File: tb/test_wave_timer.sv
module test_wave_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cntWrEn = 1'b0;
  logic [7:0] cntWrData = '0;
  logic       cmpWrEn = 1'b0;
  logic [7:0] cmpWrData = '0;
  logic       ctlWrEn = 1'b0;
  logic [1:0] ctlMode = '0;
  logic [1:0] ctlOut = '0;
  logic       pinDir = 1'b0;
  logic       ovfClr = 1'b0;
  logic       cmpClr = 1'b0;
  logic [7:0] count;
  logic       waveOut, pinOvr, pinDrvEn, ovfFlag, cmpFlag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wave_timer i_wave_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData),
    .ctlWrEn(ctlWrEn), .ctlMode(ctlMode), .ctlOut(ctlOut),
    .pinDir(pinDir), .ovfClr(ovfClr), .cmpClr(cmpClr),
    .count(count), .waveOut(waveOut), .pinOvr(pinOvr), .pinDrvEn(pinDrvEn),
    .ovfFlag(ovfFlag), .cmpFlag(cmpFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runTicks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic measureHigh(input int n, output int hi);
    hi = 0;
    tick = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (waveOut) hi++;
    end
    tick = 1'b0;
  endtask

  task automatic setCtl(input logic [1:0] m, input logic [1:0] o);
    ctlMode = m; ctlOut = o; ctlWrEn = 1'b1;
    @(negedge clk); ctlWrEn = 1'b0;
  endtask

  task automatic writeCnt(input logic [7:0] v);
    cntWrData = v; cntWrEn = 1'b1;
    @(negedge clk); cntWrEn = 1'b0;
  endtask

  task automatic writeCmp(input logic [7:0] v);
    cmpWrData = v; cmpWrEn = 1'b1;
    @(negedge clk); cmpWrEn = 1'b0;
  endtask

  task automatic clearFlags();
    ovfClr = 1'b1; cmpClr = 1'b1;
    @(negedge clk); ovfClr = 1'b0; cmpClr = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 reset count", count, 0);
    chk("R12 reset ovfFlag", ovfFlag, 0);
    chk("R12 reset cmpFlag", cmpFlag, 0);
    chk("R4 reset waveOut", waveOut, 0);
    chk("R10 reset pinOvr", pinOvr, 0);
  endtask

  task automatic testHoldAndWrite();
    repeat (5) @(negedge clk);
    chk("R1 hold without tick", count, 0);
    runTicks(3);
    chk("R1 three ticks", count, 3);
    tick = 1'b1; cntWrData = 8'd100; cntWrEn = 1'b1;
    @(negedge clk); cntWrEn = 1'b0; tick = 1'b0;
    chk("R1 write beats tick", count, 100);
  endtask

  task automatic testNormalOverflow();
    setCtl(2'd0, 2'd0);
    writeCnt(8'hFD);
    clearFlags();
    runTicks(2);
    chk("R2 count at 255", count, 255);
    chk("R2 no ovf before wrap", ovfFlag, 0);
    runTicks(1);
    chk("R2 wrap to 0", count, 0);
    chk("R2 ovf on wrap", ovfFlag, 1);
    repeat (5) @(negedge clk);
    chk("R12 ovf sticky", ovfFlag, 1);
    ovfClr = 1'b1; @(negedge clk); ovfClr = 1'b0;
    chk("R12 ovf cleared", ovfFlag, 0);
  endtask

  task automatic testNonPwmActions();
    setCtl(2'd0, 2'd1);
    writeCmp(8'd10);
    writeCnt(8'd5);
    clearFlags();
    runTicks(5);
    chk("R4 no change before match", waveOut, 0);
    chk("R4 no flag before match", cmpFlag, 0);
    runTicks(1);
    chk("R4 toggle on match", waveOut, 1);
    chk("R12 cmp flag set", cmpFlag, 1);
    setCtl(2'd0, 2'd2);
    writeCnt(8'd5);
    runTicks(6);
    chk("R4 clear on match", waveOut, 0);
    setCtl(2'd0, 2'd3);
    writeCnt(8'd5);
    runTicks(6);
    chk("R4 set on match", waveOut, 1);
  endtask

  task automatic testBlock();
    setCtl(2'd0, 2'd1);
    writeCmp(8'd20);
    writeCnt(8'd20);
    clearFlags();
    runTicks(1);
    chk("R11 count moved", count, 21);
    chk("R11 no toggle after write", waveOut, 1);
    chk("R11 no flag after write", cmpFlag, 0);
  endtask

  task automatic testCtc();
    int hi;
    setCtl(2'd2, 2'd1);
    writeCmp(8'd9);
    writeCnt(8'd0);
    clearFlags();
    runTicks(9);
    chk("R3 reaches compare", count, 9);
    runTicks(1);
    chk("R3 wraps at compare", count, 0);
    chk("R3 no ovf at compare", ovfFlag, 0);
    measureHigh(20, hi);
    chk("R4 ctc toggle half duty", hi, 10);
    writeCnt(8'hFE);
    runTicks(2);
    chk("R3 wraps past max", count, 0);
    chk("R3 ovf at max", ovfFlag, 1);
  endtask

  task automatic testFast();
    int hi;
    setCtl(2'd3, 2'd2);
    writeCmp(8'd100);
    writeCnt(8'd0);
    clearFlags();
    runTicks(10);
    chk("R5 held compare not yet active", cmpFlag, 1);
    chk("R6 clear on old match", waveOut, 0);
    runTicks(300);
    measureHigh(256, hi);
    chk("R6 non-inverting duty", hi, 101);
    setCtl(2'd3, 2'd3);
    runTicks(256);
    measureHigh(256, hi);
    chk("R6 inverting duty", hi, 155);
    setCtl(2'd3, 2'd1);
    measureHigh(300, hi);
    chk("R6 reserved action holds pin", hi, waveOut ? 300 : 0);
    setCtl(2'd3, 2'd2);
    writeCmp(8'hFF);
    runTicks(300);
    measureHigh(256, hi);
    chk("R7 compare at top stays high", hi, 256);
    setCtl(2'd3, 2'd3);
    runTicks(256);
    measureHigh(256, hi);
    chk("R7 compare at top inverted stays low", hi, 0);
  endtask

  task automatic testPhase();
    int hi;
    setCtl(2'd1, 2'd0);
    writeCnt(8'hFD);
    clearFlags();
    runTicks(2);
    chk("R8 rise to top", count, 255);
    runTicks(1);
    chk("R8 turn at top", count, 254);
    chk("R8 no ovf at top", ovfFlag, 0);
    writeCnt(8'd2);
    runTicks(2);
    chk("R8 fall to bottom", count, 0);
    chk("R8 no ovf yet", ovfFlag, 0);
    runTicks(1);
    chk("R8 turn at bottom", count, 1);
    chk("R8 ovf at bottom", ovfFlag, 1);
    setCtl(2'd1, 2'd2);
    writeCmp(8'd64);
    runTicks(1100);
    measureHigh(510, hi);
    chk("R9 phase non-inverting duty", hi, 128);
    setCtl(2'd1, 2'd3);
    runTicks(510);
    measureHigh(510, hi);
    chk("R9 phase inverting duty", hi, 382);
  endtask

  task automatic testPin();
    pinDir = 1'b0;
    setCtl(2'd0, 2'd0);
    chk("R10 off: no override", pinOvr, 0);
    chk("R10 off: no driver", pinDrvEn, 0);
    setCtl(2'd0, 2'd2);
    chk("R10 override on", pinOvr, 1);
    chk("R10 driver needs direction", pinDrvEn, 0);
    pinDir = 1'b1; @(negedge clk);
    chk("R10 driver enabled", pinDrvEn, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testHoldAndWrite();
    testNormalOverflow();
    testNonPwmActions();
    testBlock();
    testCtc();
    testFast();
    testPhase();
    testPin();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule